// File: doc/BRIEF.md
# Checksummed Serial Configuration Receiver

This block takes 48-bit configuration words from a three-wire serial link made of a strobe, a bit clock and a data line. All three wires are brought into the system clock domain before any edge is detected. Bits are collected on bit-clock rises, least significant first. A rise of the strobe closes the frame. At that point the word is judged on four points: its length, its device address byte, its category code and its modular byte sum. A frame that passes all four has its 28-bit payload written into the register bank that the category selects.

The four banks are always visible as outputs. Each bank has a one-cycle load pulse that fires in the same cycle as the bank update, so a consumer can pick up the new settings. These outputs are plain register outputs with no handshake. A load pulse is a single-cycle event that cannot be held off, so a consumer that needs it must sample it on every cycle.

Two bits of the system bank control the block itself. One enables the checksum test. The other routes the frame verdict onto a status pin while the strobe is high. Both bits act with the values stored before the frame that is being judged.

Top module: `cfg_serial_rx`

## Requirements
- R1: Data is sampled at each rising edge of the serial clock. The first bit sampled becomes word bit 0 and the 48th becomes bit 47. The word is judged at the rising edge of the strobe.
- R2: A frame is judged only if exactly 48 serial clock rises occurred since the previous strobe rise. If the count is 47, 49 or any other value, the frame is discarded.
- R3: Word bits 7:0 must equal 8'h81 (bits 0 and 7 set, bits 1 to 6 clear). Any other address byte rejects the frame.
- R4: Word bits 11:8 select the bank. Code 0 selects mode, code 2 shutter, code 3 phase and code 4 system. Every other code rejects the frame.
- R5: When checking is enabled, the six bytes of the word (bits 8k+7:8k, k = 0 to 5) must add to zero modulo 256. A frame that fails leaves every bank unchanged and fires no load pulse.
- R6: The checksum-enable bit is system bank bit 5 (word bit 17). When it is 0, a frame with a correct address, length and category passes whatever its checksum byte holds. The value in force before the frame is the one used.
- R7: An accepted frame writes word bits 39:12 into the selected bank. In the same cycle it raises bit 0 (mode), 1 (shutter), 2 (phase) or 3 (system) of `load_o` for exactly one cycle. At most one bit of `load_o` is high at any time.
- R8: The status-select bit is system bank bit 6 (word bit 18). While it is 0, `status_o` is low. While it is set, a strobe rise drives `status_o` to the acceptance verdict and a strobe fall drives it high. The stored select bit in force at each edge governs that edge.
- R9: While active-low reset is asserted, all banks, `load_o` and `status_o` are zero.
- R10: If a serial clock rise and a strobe rise reach the block in the same cycle, the strobe wins. That clock rise is not counted toward the frame being judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_strobe_i | input | 1 | Serial strobe; its rise closes and judges a frame |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous to clk |
| ser_data_i | input | 1 | Serial data, bit 0 first |
| mode_o | output | 28 | Mode category bank |
| shutter_o | output | 28 | Shutter category bank |
| phase_o | output | 28 | Phase-adjust category bank |
| system_o | output | 28 | System category bank (bit 5 checksum enable, bit 6 status select) |
| load_o | output | 4 | One-cycle load pulse per bank |
| status_o | output | 1 | Frame verdict while the strobe is high |

## Verification
Two pairs of events can land in the same clock cycle, and the bench provokes both.

- A frame written to the system category can change the checksum-enable and status-select bits on the same edge that judges that very frame. The bench sends system frames that switch checking off while carrying a bad checksum, and frames that clear or set the status select. Its model judges each frame with the settings stored beforehand, then checks the status pin both after the rise and after the fall.
- The strobe rise and the 48th serial clock rise can arrive together. The bench drives both in one cycle and expects the frame to be discarded. Random system payloads keep toggling both control bits during the random phase.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  localparam int WORD_W   = 48;
  localparam int NBYTES   = WORD_W / 8;
  localparam int PAY_LSB  = 12;
  localparam int PAY_W    = 28;
  localparam int CODE_LSB = 8;
  localparam int CODE_W   = 4;
  localparam int NCAT     = 4;
  localparam int CNT_W    = $clog2(WORD_W + 2);
  localparam logic [7:0] ADDR_KEY = 8'h81;
  // category codes, index 0 mode, 1 shutter, 2 phase, 3 system
  localparam logic [NCAT-1:0][CODE_W-1:0] CAT_CODES = {4'h4, 4'h3, 4'h2, 4'h0};
  localparam int IDX_SYS       = 3;
  localparam int SYS_CHKEN_BIT = 5;
  localparam int SYS_STSEL_BIT = 6;
endpackage

// File: rtl/cfg_rx_sync.sv
module cfg_rx_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [STAGES-1:0][N-1:0] pipe;
  logic [N-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= raw_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl_o  = pipe[STAGES-1];
  assign rise_o = pipe[STAGES-1] & ~prev;
  assign fall_o = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/cfg_rx_shifter.sv
module cfg_rx_shifter
  import cfg_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise_i,
  input  logic              din_i,
  input  logic              frame_clr_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      cnt_o  <= '0;
    end else if (frame_clr_i) begin
      cnt_o <= '0;
    end else if (bit_rise_i) begin
      word_o <= {din_i, word_o[WORD_W-1:1]};
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_rx_judge.sv
module cfg_rx_judge
  import cfg_rx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              chk_en_i,
  output logic              accept_o,
  output logic [NCAT-1:0]   wr_sel_o
);
  logic [7:0]        sum;
  logic [NCAT-1:0]   cat_sel;
  logic              len_ok, addr_ok, sum_ok;
  logic [CODE_W-1:0] code;

  assign code = word_i[CODE_LSB +: CODE_W];

  always_comb begin
    sum = '0;
    for (int b = 0; b < NBYTES; b++) sum = sum + word_i[b*8 +: 8];
  end

  for (genvar i = 0; i < NCAT; i++) begin : g_dec
    assign cat_sel[i] = (code == CAT_CODES[i]);
  end

  assign len_ok   = (cnt_i == CNT_W'(WORD_W));
  assign addr_ok  = (word_i[7:0] == ADDR_KEY);
  assign sum_ok   = !chk_en_i || (sum == 8'd0);
  assign accept_o = len_ok && addr_ok && (|cat_sel) && sum_ok;
  assign wr_sel_o = accept_o ? cat_sel : '0;
endmodule

// File: rtl/cfg_rx_banks.sv
module cfg_rx_banks
  import cfg_rx_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCAT-1:0]            wr_i,
  input  logic [PAY_W-1:0]           pay_i,
  output logic [NCAT-1:0][PAY_W-1:0] bank_o,
  output logic [NCAT-1:0]            load_o
);
  for (genvar i = 0; i < NCAT; i++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_o[i] <= '0;
        load_o[i] <= 1'b0;
      end else begin
        load_o[i] <= wr_i[i];
        if (wr_i[i]) bank_o[i] <= pay_i;
      end
    end
  end
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_strobe_i,
  input  logic             ser_clk_i,
  input  logic             ser_data_i,
  output logic [PAY_W-1:0] mode_o,
  output logic [PAY_W-1:0] shutter_o,
  output logic [PAY_W-1:0] phase_o,
  output logic [PAY_W-1:0] system_o,
  output logic [NCAT-1:0]  load_o,
  output logic             status_o
);
  logic [2:0] lvl, rise, fall;
  logic       strb_rise, strb_fall, bit_rise, din;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              accept;
  logic [NCAT-1:0]   wr_sel, wr_en;
  logic [NCAT-1:0][PAY_W-1:0] banks;
  logic              chk_en, st_sel;

  cfg_rx_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw_i({ser_data_i, ser_clk_i, ser_strobe_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign strb_rise = rise[0];
  assign strb_fall = fall[0];
  assign bit_rise  = rise[1];
  assign din       = lvl[2];

  cfg_rx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .bit_rise_i(bit_rise), .din_i(din),
    .frame_clr_i(strb_rise), .word_o(word), .cnt_o(bit_cnt)
  );

  assign chk_en = banks[IDX_SYS][SYS_CHKEN_BIT];
  assign st_sel = banks[IDX_SYS][SYS_STSEL_BIT];

  cfg_rx_judge u_judge (
    .word_i(word), .cnt_i(bit_cnt), .chk_en_i(chk_en),
    .accept_o(accept), .wr_sel_o(wr_sel)
  );

  assign wr_en = strb_rise ? wr_sel : '0;

  cfg_rx_banks u_banks (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en),
    .pay_i(word[PAY_LSB +: PAY_W]), .bank_o(banks), .load_o(load_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_o <= 1'b0;
    else if (!st_sel)   status_o <= 1'b0;
    else if (strb_rise) status_o <= accept;
    else if (strb_fall) status_o <= 1'b1;
  end

  assign mode_o    = banks[0];
  assign shutter_o = banks[1];
  assign phase_o   = banks[2];
  assign system_o  = banks[3];
endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk
  import cfg_rx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NCAT-1:0]  load_o,
  input logic [PAY_W-1:0] mode_o,
  input logic [PAY_W-1:0] shutter_o,
  input logic [PAY_W-1:0] phase_o,
  input logic [PAY_W-1:0] system_o,
  input logic             status_o,
  input logic             strb_rise,
  input logic             strb_fall,
  input logic [CNT_W-1:0] bit_cnt
);
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o)); // R7
  AST_LOAD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_o) |-> $past(strb_rise)); // R1
  AST_LOAD_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_o) |-> ($past(bit_cnt) == CNT_W'(WORD_W))); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o[0] |-> $stable(mode_o)); // R5
  AST_SHUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o[1] |-> $stable(shutter_o)); // R5
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o[2] |-> $stable(phase_o)); // R5
  AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o[3] |-> $stable(system_o)); // R5
  AST_STATUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(system_o[SYS_STSEL_BIT]) |-> !status_o); // R8
  AST_STATUS_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strb_fall) && $past(system_o[SYS_STSEL_BIT])) |-> status_o); // R8
endmodule

bind cfg_serial_rx cfg_serial_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_o(load_o), .mode_o(mode_o),
  .shutter_o(shutter_o), .phase_o(phase_o), .system_o(system_o),
  .status_o(status_o), .strb_rise(strb_rise), .strb_fall(strb_fall),
  .bit_cnt(bit_cnt)
);

// File: tb/cfg_serial_rx_bench.sv
`timescale 1ns/1ps
module cfg_serial_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [27:0] mode_o, shutter_o, phase_o, system_o;
  logic [3:0]  load_o;
  logic        status_o;
  int n_cmp = 0, n_bad = 0;
  int ld_cnt [4];
  logic ld_clr = 1'b0;
  logic [27:0] mdl [4];

  always #4 clk = ~clk;

  cfg_serial_rx u_cfg_serial_rx (
    .clk(clk), .rst_n(rst_n), .ser_strobe_i(stb), .ser_clk_i(sck),
    .ser_data_i(sdi), .mode_o(mode_o), .shutter_o(shutter_o),
    .phase_o(phase_o), .system_o(system_o), .load_o(load_o),
    .status_o(status_o)
  );

  always @(posedge clk)
    for (int k = 0; k < 4; k++) ld_cnt[k] <= ld_clr ? 0 : ld_cnt[k] + int'(load_o[k]);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(logic [7:0] a, logic [3:0] c, logic [27:0] p, bit good);
    logic [47:0] w;
    logic [7:0]  s;
    w = '0; w[7:0] = a; w[11:8] = c; w[39:12] = p;
    s = 8'd0;
    for (int b = 0; b < 5; b++) s = s + w[b*8 +: 8];
    w[47:40] = (8'd0 - s) + (good ? 8'd0 : 8'd1);
    return w;
  endfunction

  function automatic int cat_idx(logic [3:0] c);
    case (c)
      4'h0: return 0;
      4'h2: return 1;
      4'h3: return 2;
      4'h4: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit sum_ok(logic [47:0] w);
    logic [7:0] s;
    s = 8'd0;
    for (int b = 0; b < 6; b++) s = s + w[b*8 +: 8];
    return s == 8'd0;
  endfunction

  task automatic check_banks(input string tag);
    check({tag, " mode bank"},    {4'h0, mode_o},    {4'h0, mdl[0]});
    check({tag, " shutter bank"}, {4'h0, shutter_o}, {4'h0, mdl[1]});
    check({tag, " phase bank"},   {4'h0, phase_o},   {4'h0, mdl[2]});
    check({tag, " system bank"},  {4'h0, system_o},  {4'h0, mdl[3]});
  endtask

  task automatic run_frame(input logic [47:0] w, input int nbits, input bit coincide, input string tag);
    int ci;
    bit old_en, old_sel, acc;
    old_en  = mdl[3][5];
    old_sel = mdl[3][6];
    ci  = cat_idx(w[11:8]);
    acc = (nbits == 48) && !coincide && (w[7:0] == 8'h81) && (ci >= 0) && (!old_en || sum_ok(w));
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sdi = (i < 48) ? w[i] : 1'b1; sck = 1'b0;
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (3) @(negedge clk);
    end
    @(negedge clk); sck = 1'b0;
    if (coincide) sdi = w[47];
    repeat (4) @(negedge clk);
    ld_clr = 1'b1; @(negedge clk); ld_clr = 1'b0;
    if (coincide) sck = 1'b1;
    stb = 1'b1;
    repeat (8) @(negedge clk);
    if (acc) mdl[ci] = w[39:12];
    check_banks(tag);
    for (int k = 0; k < 4; k++)
      check($sformatf("%s R7 load pulses bank %0d", tag, k), ld_cnt[k], (acc && ci == k) ? 1 : 0);
    check({tag, " R8 status after strobe rise"}, {31'd0, status_o}, {31'd0, old_sel & mdl[3][6] & acc});
    stb = 1'b0; sck = 1'b0;
    repeat (8) @(negedge clk);
    check({tag, " R8 status after strobe fall"}, {31'd0, status_o}, {31'd0, mdl[3][6]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] a;
    logic [3:0] c;
    int nb;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) mdl[k] = '0;
    repeat (5) @(negedge clk);
    check_banks("R9 reset");
    check("R9 reset load", {28'd0, load_o}, 32'd0);
    check("R9 reset status", {31'd0, status_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_frame(mk(8'h81, 4'h0, 28'hA5C3E17, 1'b1), 48, 1'b0, "R7 mode write");
    run_frame(mk(8'h81, 4'h3, 28'h8000001, 1'b1), 48, 1'b0, "R1 bit order");
    run_frame(mk(8'h81, 4'h2, 28'h1234567, 1'b0), 48, 1'b0, "R6 check off bad sum");
    run_frame(mk(8'h81, 4'h4, 28'h0000060, 1'b1), 48, 1'b0, "R8 enable check and status");
    run_frame(mk(8'h81, 4'h2, 28'h7654321, 1'b0), 48, 1'b0, "R5 bad sum rejected");
    run_frame(mk(8'h81, 4'h2, 28'h0FEDCBA, 1'b1), 48, 1'b0, "R5 good sum accepted");
    run_frame(mk(8'h80, 4'h0, 28'h1111111, 1'b1), 48, 1'b0, "R3 address 80");
    run_frame(mk(8'h01, 4'h0, 28'h2222222, 1'b1), 48, 1'b0, "R3 address 01");
    run_frame(mk(8'hC1, 4'h0, 28'h3333333, 1'b1), 48, 1'b0, "R3 address C1");
    run_frame(mk(8'h81, 4'h1, 28'h4444444, 1'b1), 48, 1'b0, "R4 code 1");
    run_frame(mk(8'h81, 4'h5, 28'h5555555, 1'b1), 48, 1'b0, "R4 code 5");
    run_frame(mk(8'h81, 4'hF, 28'h6666666, 1'b1), 48, 1'b0, "R4 code F");
    run_frame(mk(8'h81, 4'h0, 28'h7777777, 1'b1), 47, 1'b0, "R2 length 47");
    run_frame(mk(8'h81, 4'h0, 28'h8888888, 1'b1), 49, 1'b0, "R2 length 49");
    run_frame(mk(8'h81, 4'h0, 28'h9999999, 1'b1), 47, 1'b1, "R10 clock with strobe");
    run_frame(mk(8'h81, 4'h4, 28'h0000000, 1'b0), 48, 1'b0, "R6 old enable governs");
    run_frame(mk(8'h81, 4'h4, 28'h0000000, 1'b1), 48, 1'b0, "R8 select cleared");
    run_frame(mk(8'h81, 4'h3, 28'h0ABCDEF, 1'b0), 48, 1'b0, "R6 check off again");

    for (int n = 0; n < 60; n++) begin
      a  = ($urandom % 10 != 0) ? 8'h81 : 8'($urandom);
      case ($urandom % 6)
        0: c = 4'h0;
        1: c = 4'h2;
        2: c = 4'h3;
        3: c = 4'h4;
        4: c = 4'h4;
        default: c = 4'($urandom);
      endcase
      nb = ($urandom % 10 == 0) ? (($urandom % 2 == 0) ? 47 : 49) : 48;
      run_frame(mk(a, c, 28'($urandom), ($urandom % 4) != 0), nb, 1'b0, "R5 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule